// File: doc/BRIEF.md
# NAND Page ECC Generator

This block computes Hamming-style error-correcting codes on the fly over the bytes that stream toward NAND flash. Every byte presented with its valid strobe is folded into a running parity accumulator. Nothing is buffered, so the codes are ready on the same clock edge that accepts the last byte of a block.

A one-bit mode register chooses the block size. In mode 0 the page is split into two 256-byte blocks, and each block gets its own 3-byte code in a separate code register (first code, second code). In mode 1 a single code covers all 512 bytes; it can locate any single flipped bit and reveal any two flipped bits. A restart strobe clears the accumulators and the byte counter and sets both code registers back to their cleared value. A done flag marks the end of the page, and bytes after that are ignored until the next restart.

Each code holds two kinds of parity. Column parities cover the bit positions within a byte. Line parities cover the byte index. Both kinds come in even/odd pairs, and the code is presented inverted so that an erased (all-ones) page yields an all-ones code.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset, mode_o is 0, done_o is 0, and ecc1_o and ecc2_o both read all ones.
- R2: A cycle with mode_wr high loads mode_wdat into the mode bit, and mode_o shows it from the next cycle on.
- R3: A cycle with ecc_restart high clears the accumulator and byte counter, drops done_o, and sets both code outputs to all ones from the next cycle. A byte presented in that same cycle is dropped.
- R4: Code layout before inversion: bit 2k is the parity of all data bits whose bit position has bit k equal to 0, and bit 2k+1 is the parity of those with bit k equal to 1 (k = 0..2). Bit 6+2j is the parity of all bytes whose block index has bit j equal to 0, and bit 7+2j is the parity of those with bit j equal to 1. The output is the bitwise inverse, and unused bits read 1.
- R5: In mode 0 the first 256 accepted bytes after a restart form ecc1_o (line index bits 0..7, so bits 22 and 23 read 1). The code appears on the edge that accepts byte 255, and until then ecc1_o reads all ones.
- R6: In mode 0 the next 256 accepted bytes form ecc2_o, with their index counted from 0 within the block. ecc2_o reads all ones until the edge that accepts the last of them.
- R7: In mode 1 all 512 accepted bytes form one code in ecc1_o, using line index bits 0..8 (bits 22 and 23 carry index bit 8). ecc2_o stays all ones.
- R8: In mode 1, flipping one data bit of the page changes exactly 12 bits of the code, one in each of the 12 parity pairs.
- R9: Cycles with byte_vld low neither count nor alter any output.
- R10: done_o rises on the edge that accepts byte 511 (the last byte of the page in either mode) and stays high until a restart.
- R11: While done_o is high, further valid bytes leave both codes unchanged.
- R12: A page of all-ones bytes gives all-ones codes in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_wdat | input | 1 | Mode value: 0 = two 256-byte codes, 1 = one 512-byte code |
| ecc_restart | input | 1 | Restart strobe: clears codes, counter and done |
| byte_vld | input | 1 | Data byte valid |
| byte_dat | input | 8 | Data byte |
| mode_o | output | 1 | Current mode bit |
| ecc1_o | output | 24 | First code (inverted) |
| ecc2_o | output | 24 | Second code (inverted), mode 0 only |
| done_o | output | 1 | Page complete |

## Verification
An incrementing byte pattern in mode 0 separates the two blocks. It also shows whether the index restarts at block two and whether each code register stays cleared until its own last byte. An all-ones page tells apart a correct inversion and pair layout from one that merely looks plausible. A pseudo-random mode-1 page sent with gaps in the valid strobe, then sent again with one bit flipped, checks that index bit 8 is included and that a single error touches exactly one bit of each pair. A restart in the middle of a stream, a byte coinciding with the restart, and bytes after done expose counter and clear faults.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int BYTE_W = 8;
  localparam int COL_W  = 6;

  // parity of one data byte
  function automatic logic byte_parity(input logic [BYTE_W-1:0] d);
    return ^d;
  endfunction

  // even/odd column parity pairs of one byte: [2k] even, [2k+1] odd
  function automatic logic [COL_W-1:0] col_parity(input logic [BYTE_W-1:0] d);
    logic [COL_W-1:0] c;
    c = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      for (int k = 0; k < 3; k++) begin
        if (((b >> k) & 1) != 0) c[2*k+1] = c[2*k+1] ^ d[b];
        else                     c[2*k]   = c[2*k]   ^ d[b];
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq #(
  parameter int BLK_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              byte_vld,
  input  logic              mode,
  output logic              take,
  output logic              blk_end,
  output logic              first_blk,
  output logic              done,
  output logic [BLK_AW:0]   idx,
  output logic [BLK_AW:0]   idx_mask
);
  logic [BLK_AW:0] cnt_q;
  logic            done_q;
  logic            page_end;

  assign take      = byte_vld && !done_q && !restart;
  assign page_end  = take && (cnt_q == '1);
  assign blk_end   = mode ? page_end : (take && (cnt_q[BLK_AW-1:0] == '1));
  assign first_blk = mode ? 1'b1 : !cnt_q[BLK_AW];
  assign idx       = cnt_q;
  assign idx_mask  = mode ? '1 : {1'b0, {BLK_AW{1'b1}}};
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (page_end) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
#(
  parameter int LW = 9,
  localparam int CW = 2*LW + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [BYTE_W-1:0] d,
  input  logic [LW-1:0]     idx,
  input  logic [LW-1:0]     idx_mask,
  output logic [CW-1:0]     acc_nxt
);
  logic [CW-1:0] acc_q;
  logic [CW-1:0] contrib;
  logic          bp;

  assign bp = byte_parity(d);
  assign contrib[COL_W-1:0] = col_parity(d);

  for (genvar j = 0; j < LW; j++) begin : g_line
    assign contrib[COL_W+2*j]   = idx_mask[j] & ~idx[j] & bp;
    assign contrib[COL_W+2*j+1] = idx_mask[j] &  idx[j] & bp;
  end

  assign acc_nxt = take ? (acc_q ^ contrib) : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clear)  acc_q <= '0;
    else             acc_q <= acc_nxt;
  end
endmodule

// File: rtl/nand_ecc_store.sv
module nand_ecc_store #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          load,
  input  logic          to_first,
  input  logic [CW-1:0] raw,
  output logic [CW-1:0] ecc1,
  output logic [CW-1:0] ecc2
);
  logic [CW-1:0] r1_q, r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= '0;
      r2_q <= '0;
    end else if (restart) begin
      r1_q <= '0;
      r2_q <= '0;
    end else if (load) begin
      if (to_first) r1_q <= raw;
      else          r2_q <= raw;
    end
  end

  assign ecc1 = ~r1_q;
  assign ecc2 = ~r2_q;
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int BLK_AW = 8,
  localparam int LW = BLK_AW + 1,
  localparam int CW = 2*LW + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_wdat,
  input  logic              ecc_restart,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  output logic              mode_o,
  output logic [CW-1:0]     ecc1_o,
  output logic [CW-1:0]     ecc2_o,
  output logic              done_o
);
  logic          mode_q;
  logic          take, blk_end, first_blk;
  logic [LW-1:0] idx, idx_mask;
  logic [CW-1:0] acc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_wr) mode_q <= mode_wdat;
  end
  assign mode_o = mode_q;

  nand_ecc_seq #(.BLK_AW(BLK_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(ecc_restart), .byte_vld(byte_vld),
    .mode(mode_q), .take(take), .blk_end(blk_end), .first_blk(first_blk),
    .done(done_o), .idx(idx), .idx_mask(idx_mask)
  );

  nand_ecc_acc #(.LW(LW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(ecc_restart | blk_end), .take(take),
    .d(byte_dat), .idx(idx), .idx_mask(idx_mask), .acc_nxt(acc_nxt)
  );

  nand_ecc_store #(.CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .restart(ecc_restart), .load(blk_end),
    .to_first(first_blk), .raw(acc_nxt), .ecc1(ecc1_o), .ecc2(ecc2_o)
  );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          byte_vld,
  input logic          blk_end,
  input logic [CW-1:0] ecc1,
  input logic [CW-1:0] ecc2,
  input logic          done
);
  // R3
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ecc1 == {CW{1'b1}}) && (ecc2 == {CW{1'b1}}) && !done);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !restart) |=> ($stable(ecc1) && $stable(ecc2) && $stable(done)));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> done);

  // R10
  done_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(blk_end));

  // R11
  done_freezes_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> ($stable(ecc1) && $stable(ecc2)));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(ecc_restart), .byte_vld(byte_vld),
  .blk_end(blk_end), .ecc1(ecc1_o), .ecc2(ecc2_o), .done(done_o)
);

// File: tb/tb_nand_ecc_gen.sv
module tb_nand_ecc_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0, mode_wdat = 1'b0;
  logic        ecc_restart = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_dat = 8'h00;
  logic        mode_o, done_o;
  logic [23:0] ecc1_o, ecc2_o;

  logic [7:0]  mem [0:511];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  nand_ecc_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdat(mode_wdat),
    .ecc_restart(ecc_restart), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .mode_o(mode_o), .ecc1_o(ecc1_o), .ecc2_o(ecc2_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected code, bit by bit, over mem[base +: n]; index bits used = log2(n)
  function automatic logic [23:0] ref_code(input int base, input int n);
    logic [23:0] raw = '0;
    int lw = (n == 512) ? 9 : 8;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (mem[base+i][b]) begin
          for (int k = 0; k < 3; k++)
            raw[((b >> k) & 1) ? 2*k+1 : 2*k] ^= 1'b1;
          for (int k = 0; k < lw; k++)
            raw[((i >> k) & 1) ? 7+2*k : 6+2*k] ^= 1'b1;
        end
    return ~raw;
  endfunction

  task automatic set_mode(input logic m);
    mode_wr = 1'b1; mode_wdat = m;
    @(negedge clk);
    mode_wr = 1'b0;
    check("R2 mode_o", {23'd0, mode_o}, {23'd0, m});
  endtask

  task automatic restart(input bit with_byte);
    ecc_restart = 1'b1;
    byte_vld = with_byte; byte_dat = 8'hA5;
    @(negedge clk);
    ecc_restart = 1'b0; byte_vld = 1'b0;
    check("R3 ecc1 cleared", ecc1_o, 24'hFFFFFF);
    check("R3 ecc2 cleared", ecc2_o, 24'hFFFFFF);
    check("R3 done low", {23'd0, done_o}, 24'd0);
  endtask

  task automatic send(input int base, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_dat = mem[base+i];
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        byte_vld = 1'b0; byte_dat = ~mem[base+i];
        @(negedge clk);
      end
    end
    byte_vld = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mode", {23'd0, mode_o}, 24'd0);
    check("R1 done", {23'd0, done_o}, 24'd0);
    check("R1 ecc1", ecc1_o, 24'hFFFFFF);
    check("R1 ecc2", ecc2_o, 24'hFFFFFF);
  endtask

  task automatic t_mode0_ramp;
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 5));
    set_mode(1'b0);
    restart(1'b0);
    send(0, 255, 1'b0);
    check("R5 ecc1 held before block end", ecc1_o, 24'hFFFFFF);
    send(255, 1, 1'b0);
    check("R5 R4 ecc1 first block", ecc1_o, ref_code(0, 256));
    check("R5 ecc1 bits 23:22", {22'd0, ecc1_o[23:22]}, 24'd3);
    check("R6 ecc2 held", ecc2_o, 24'hFFFFFF);
    send(256, 255, 1'b0);
    check("R6 ecc2 before end", ecc2_o, 24'hFFFFFF);
    check("R10 done low before end", {23'd0, done_o}, 24'd0);
    send(511, 1, 1'b0);
    check("R6 ecc2 second block", ecc2_o, ref_code(256, 256));
    check("R10 done high", {23'd0, done_o}, 24'd1);
  endtask

  task automatic t_erased;
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    set_mode(1'b0);
    restart(1'b0);
    send(0, 512, 1'b0);
    check("R12 mode0 ecc1", ecc1_o, 24'hFFFFFF);
    check("R12 mode0 ecc2", ecc2_o, 24'hFFFFFF);
    set_mode(1'b1);
    restart(1'b0);
    send(0, 512, 1'b0);
    check("R12 mode1 ecc1", ecc1_o, 24'hFFFFFF);
    check("R12 mode1 done", {23'd0, done_o}, 24'd1);
  endtask

  task automatic t_mode1_flip;
    logic [23:0] good, bad;
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 512; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem[i] = lfsr[7:0];
    end
    set_mode(1'b1);
    restart(1'b0);
    send(0, 512, 1'b1);
    good = ecc1_o;
    check("R7 R9 ecc1 page code", good, ref_code(0, 512));
    check("R7 ecc2 unused", ecc2_o, 24'hFFFFFF);
    check("R10 done mode1", {23'd0, done_o}, 24'd1);
    send(0, 20, 1'b0);
    check("R11 ecc1 after done", ecc1_o, good);
    check("R11 ecc2 after done", ecc2_o, 24'hFFFFFF);
    mem[300] = mem[300] ^ 8'h20;
    restart(1'b0);
    send(0, 512, 1'b0);
    bad = ecc1_o;
    check("R8 flipped page code", bad, ref_code(0, 512));
    check("R8 changed bits", 24'($countones(good ^ bad)), 24'd12);
  endtask

  task automatic t_mid_restart;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 13 + 1);
    set_mode(1'b0);
    restart(1'b0);
    send(0, 100, 1'b0);
    restart(1'b1);
    send(200, 256, 1'b0);
    check("R3 ecc1 after mid restart", ecc1_o, ref_code(200, 256));
    check("R3 ecc2 after mid restart", ecc2_o, 24'hFFFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0_ramp();
    t_erased();
    t_mode1_flip();
    t_mid_restart();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule